// File: doc/BRIEF.md
# Parallel Quarter-Rate QAM-16 Upconverter

This block is the transmit front end of a converter path whose logic runs five times slower than the converter. A producer offers one 4-bit QAM-16 symbol at a time on a valid/ready interface. The block maps the symbol to a pair of signed 5-bit in-phase and quadrature levels. It holds that pair for the whole symbol period of 16 clocks, which is 80 converter samples. It then mixes the complex baseband onto a carrier at exactly one quarter of the converter rate. Every clock it emits five real samples side by side, one per lane, and lane 0 is the earliest in time.

Because the carrier is a quarter of the sample rate, the carrier term of each sample is one of I, -Q, -I or +Q. The choice depends only on the sample's global index modulo 4, so the mixer is a four-way select with negation and needs no oscillator or multiplier. A small controller with three states sequences the block. In ST_IDLE no symbol has arrived yet. In ST_SEND a held symbol is being transmitted. In ST_STARVE a period boundary found no symbol waiting, so zeros are sent and an underflow flag is raised. The transitions all happen on a period boundary: IDLE to SEND, SEND to SEND, SEND to STARVE, STARVE to SEND and STARVE to STARVE. Between boundaries the state holds.

Top module: `ssr_quarter_upconv`

## Requirements
- R1: While the synchronous reset is high and on the first clock after it, out_valid and underflow are 0 and in_ready is 1. The clock index m used below restarts at 0 on that clock.
- R2: in_ready is 1 exactly on clocks m = 0, 16, 32, … and 0 on every other clock.
- R3: A symbol is taken when in_valid and in_ready are both 1. Bits [3:2] choose I and bits [1:0] choose Q with the Gray map 00→-15, 01→-5, 11→+5, 10→+15.
- R4: A symbol taken on clock t is transmitted on clocks t+1 through t+16, with out_valid 1 and underflow 0.
- R5: Lane k (bits [5k+4:5k] of out_samples, two's complement) on clock m carries sample s = 5m+k. The lane shows I, -Q, -I or +Q for s mod 4 equal to 0, 1, 2 or 3 respectively.
- R6: Until the first symbol is taken, out_valid and underflow are 0 and every lane is 0.
- R7: A boundary clock with in_valid 0, after at least one symbol has been taken, makes the next 16 clocks carry zero on every lane, with out_valid 1 and underflow 1.
- R8: in_valid and in_data on clocks where in_ready is 0 have no effect. A symbol offered in mid-period is taken at the next boundary.
- R9: A symbol offered at a boundary follows the previous symbol with no gap, and each symbol occupies exactly 16 output clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A symbol is offered |
| in_data | input | 4 | QAM-16 symbol, [3:2] for I and [1:0] for Q |
| in_ready | output | 1 | High on the first clock of each symbol period |
| out_samples | output | 25 | Five 5-bit signed samples, lane k at [5k+4:5k] |
| out_valid | output | 1 | Lanes carry a transmitted period |
| underflow | output | 1 | The current period is zero fill for lack of a symbol |

## Verification
On a boundary clock, two things happen in the same cycle: the lanes still carry the sixteenth clock of the outgoing symbol, and the next symbol, or the decision to starve, is taken. The bench holds in_valid high across many boundaries with a different symbol each time, including all sixteen codes. It then opens a gap that crosses several boundaries and closes it in mid-period. On every clock it compares all five lanes, in_ready, out_valid and underflow against a model of the period counter and the Gray map. A symbol that leaks in one clock early or late, or a starve decision made off the boundary, shows up as a wrong lane value.

// File: rtl/upc_pkg.sv
package upc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEND   = 2'd1,
        ST_STARVE = 2'd2
    } upc_state_e;
endpackage

// File: rtl/qam16_gray_map.sv
module qam16_gray_map #(
    parameter int W    = 5,
    parameter int STEP = 5
) (
    input  logic [3:0]          sym,
    output logic signed [W-1:0] lvl_i,
    output logic signed [W-1:0] lvl_q
);
    function automatic logic signed [W-1:0] gray_level(input logic [1:0] b);
        logic signed [W-1:0] v;
        unique case (b)
            2'b00:   v = W'(-3 * STEP);
            2'b01:   v = W'(-STEP);
            2'b11:   v = W'(STEP);
            default: v = W'(3 * STEP);
        endcase
        return v;
    endfunction

    always_comb begin
        lvl_i = gray_level(sym[3:2]);
        lvl_q = gray_level(sym[1:0]);
    end
endmodule

// File: rtl/upc_lane_mixer.sv
module upc_lane_mixer #(
    parameter int W = 5
) (
    input  logic                en,
    input  logic [1:0]          ph,
    input  logic signed [W-1:0] bb_i,
    input  logic signed [W-1:0] bb_q,
    output logic signed [W-1:0] y
);
    always_comb begin
        if (!en) begin
            y = '0;
        end else begin
            unique case (ph)
                2'd0:    y = bb_i;
                2'd1:    y = -bb_q;
                2'd2:    y = -bb_i;
                default: y = bb_q;
            endcase
        end
    end
endmodule

// File: rtl/upc_ctrl.sv
module upc_ctrl
    import upc_pkg::*;
#(
    parameter int LANES    = 5,
    parameter int SYM_CLKS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    output logic       in_ready,
    output logic       accept,
    output logic       send,
    output logic       out_valid,
    output logic       underflow,
    output logic [1:0] phase
);
    localparam int CW = (SYM_CLKS > 1) ? $clog2(SYM_CLKS) : 1;
    localparam logic [1:0] PH_STEP = 2'(LANES % 4);
    localparam logic [CW-1:0] CNT_LAST = CW'(SYM_CLKS - 1);

    upc_state_e state, nxt;
    logic [CW-1:0] cnt;
    logic at_bound;

    assign at_bound = (cnt == '0);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (at_bound && in_valid) nxt = ST_SEND;
            ST_SEND,
            ST_STARVE: if (at_bound) nxt = in_valid ? ST_SEND : ST_STARVE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            phase <= '0;
        end else begin
            cnt   <= (cnt == CNT_LAST) ? '0 : cnt + 1'b1;
            phase <= phase + PH_STEP;
        end
    end

    always_comb begin
        in_ready  = at_bound;
        accept    = at_bound && in_valid;
        send      = (state == ST_SEND);
        out_valid = (state != ST_IDLE);
        underflow = (state == ST_STARVE);
    end
endmodule

// File: rtl/ssr_quarter_upconv.sv
module ssr_quarter_upconv #(
    parameter int LANES    = 5,
    parameter int W        = 5,
    parameter int STEP     = 5,
    parameter int SYM_CLKS = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [3:0]         in_data,
    output logic               in_ready,
    output logic [LANES*W-1:0] out_samples,
    output logic               out_valid,
    output logic               underflow
);
    logic accept, send;
    logic [1:0] phase;
    logic signed [W-1:0] map_i, map_q, hold_i, hold_q;

    upc_ctrl #(.LANES(LANES), .SYM_CLKS(SYM_CLKS)) u_ctrl (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .accept(accept), .send(send), .out_valid(out_valid),
        .underflow(underflow), .phase(phase)
    );

    qam16_gray_map #(.W(W), .STEP(STEP)) u_map (
        .sym(in_data), .lvl_i(map_i), .lvl_q(map_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_i <= '0;
            hold_q <= '0;
        end else if (accept) begin
            hold_i <= map_i;
            hold_q <= map_q;
        end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [1:0] ph_k;
        logic signed [W-1:0] y_k;
        assign ph_k = phase + 2'(k % 4);
        upc_lane_mixer #(.W(W)) u_mix (
            .en(send), .ph(ph_k), .bb_i(hold_i), .bb_q(hold_q), .y(y_k)
        );
        assign out_samples[k*W +: W] = y_k;
    end
endmodule

// File: rtl/upc_chk.sv
module upc_chk #(
    parameter int LANES = 5,
    parameter int W     = 5
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               in_ready,
    input logic [LANES*W-1:0] out_samples,
    input logic               out_valid,
    input logic               underflow
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && !underflow && in_ready));

    // R2
    ready_single_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready |=> !in_ready);

    // R4
    accept_sends_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (out_valid && !underflow));

    // R7
    starve_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid && out_valid) |=> underflow);

    // R7
    starve_zero_chk: assert property (@(posedge clk) disable iff (rst)
        underflow |-> (out_valid && out_samples == '0));

    // R8
    mid_period_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(in_ready) |-> ($stable(out_valid) && $stable(underflow)));

    // R6
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_samples == '0 && !underflow));
endmodule

bind ssr_quarter_upconv upc_chk #(.LANES(LANES), .W(W)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .out_samples(out_samples), .out_valid(out_valid), .underflow(underflow)
);

// File: tb/sim_ssr_quarter_upconv.sv
module sim_ssr_quarter_upconv;
    localparam int LN = 5;
    localparam int WD = 5;
    localparam int NCYC = 460;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [3:0] in_data = 4'd0;
    logic in_ready, out_valid, underflow;
    logic [LN*WD-1:0] out_samples;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model: 0 idle, 1 send, 2 starve
    int ms = 0;
    int mcnt = 0;
    int m = 0;
    logic [3:0] msym = 4'd0;
    int sym_idx = 0;

    always #10 clk = ~clk;

    ssr_quarter_upconv u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_samples(out_samples),
        .out_valid(out_valid), .underflow(underflow)
    );

    function automatic int level(input logic [1:0] b);
        case (b)
            2'b00:   return -15;
            2'b01:   return -5;
            2'b11:   return 5;
            default: return 15;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", req, m, act, exp);
        end
    endtask

    task automatic check_outputs();
        chk("R2 in_ready", int'(in_ready), (mcnt == 0) ? 1 : 0);
        chk("R6 out_valid", int'(out_valid), (ms != 0) ? 1 : 0);
        chk("R7 underflow", int'(underflow), (ms == 2) ? 1 : 0);
        for (int k = 0; k < LN; k++) begin
            int a, e, ph;
            a = int'($signed(out_samples[k*WD +: WD]));
            ph = (5 * m + k) % 4;
            if (ms != 1) e = 0;
            else begin
                case (ph)
                    0: e = level(msym[3:2]);
                    1: e = -level(msym[1:0]);
                    2: e = -level(msym[3:2]);
                    default: e = level(msym[1:0]);
                endcase
            end
            chk((ms == 1) ? "R5 R3 lane" : "R7 R6 lane", a, e);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state held during reset
        chk("R1 ready in reset", int'(in_ready), 1);
        chk("R1 valid in reset", int'(out_valid), 0);
        chk("R1 underflow in reset", int'(underflow), 0);
        rst = 1'b0;
        for (int c = 0; c < NCYC; c++) begin
            // R4 R8 R9: model checks every clock, including boundaries
            check_outputs();
            in_valid = (c >= 20) && !(c >= 300 && c < 340);
            in_data = (sym_idx < 16) ? 4'(sym_idx) : 4'((sym_idx * 11 + 3) & 15);
            @(posedge clk);
            if (mcnt == 0) begin
                if (in_valid) begin
                    ms = 1;
                    msym = in_data;
                    sym_idx++;
                end else if (ms != 0) begin
                    ms = 2;
                end
            end
            mcnt = (mcnt + 1) % 16;
            m++;
            @(negedge clk);
        end
        chk("R3 symbols accepted", sym_idx, 24);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule